// File: doc/BRIEF.md
# Address-Tagged Broadcast Neuron Accumulator

This block is one neuron processing element on a shared broadcast bus. At any moment a single source neuron drives the bus. Every other element listens to that broadcast at the same time. The element holds a small synapse table, and each slot in the table pairs a source-neuron address with a signed synaptic weight. When a broadcast arrives, the element captures the source address and the output value. It then walks the table one slot per clock. Each slot whose address equals the captured one adds weight × value to a local accumulator.

The table can name any source on the bus, so a neuron can connect to any other neuron while storing only a few synapses. Software or a sequencer loads the slots through a write port. It clears the accumulator at the start of each layer evaluation and reads the running sum from the accumulator output. While a lookup is in progress the element raises a busy flag. The bus must hold off the next broadcast until that flag drops.

Top module: `neuron_bcast_pe`

## Requirements
- R1: After reset, `busBusy` is 0, `accOut` is 0 and every table slot is empty.
- R2: A broadcast whose address equals the address of a loaded slot adds the signed product of the slot weight (16-bit two's complement) and the broadcast value (9-bit two's complement) to the accumulator.
- R3: A broadcast whose address matches no loaded slot leaves `accOut` unchanged.
- R4: When several slots hold the same address, each of them contributes its own product to the same broadcast.
- R5: Negative weights and negative values are handled as signed numbers.
- R6: A broadcast is accepted on a clock edge where `busValid` is 1 and `busBusy` is 0. `busBusy` is then 1 for exactly 64 cycles. The final sum appears on `accOut` on the edge where `busBusy` returns to 0.
- R7: A `busValid` pulse while `busBusy` is 1 is ignored and adds nothing.
- R8: `accClear` sets `accOut` to 0 on the next edge, and it takes priority over accumulation.
- R9: A slot that has never been written never matches, not even for address 0.
- R10: Writing a slot replaces both its address and its weight.
- R11: The 32-bit accumulator holds the largest possible result: all 64 slots at weight -32768 hit by value -256, summed twice, gives 1073741824 with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | A broadcast is on the bus |
| busAddr | input | 10 | Address of the broadcasting neuron |
| busValue | input | 9 | Signed output value of the broadcasting neuron |
| busBusy | output | 1 | Lookup in progress; the bus must wait |
| tblWrEn | input | 1 | Write one table slot |
| tblWrIdx | input | 6 | Slot to write |
| tblWrAddr | input | 10 | Source address stored in the slot |
| tblWrWeight | input | 16 | Signed weight stored in the slot |
| accClear | input | 1 | Synchronous clear of the accumulator |
| accOut | output | 32 | Signed accumulator value |

## Verification
`busBusy` is due one edge after the accepting edge. It stays high for 64 edges, and the complete sum is due on the edge that lowers it. A clear is due one edge after it is applied. The bench keeps a reference model that is updated on each rising edge. The model computes the full sum of a broadcast at acceptance and counts down 64 edges before it applies that sum. On each falling edge the bench compares the busy flag with the model. It compares the accumulator only while the model is idle, because the partial sums during a scan are not specified. Named checks then compare the settled sums with values worked out by hand.

// File: rtl/neuron_pe_pkg.sv
package neuron_pe_pkg;
  typedef struct packed {
    logic capture;
    logic scanEn;
  } ctrl_strobe_t;
endpackage

// File: rtl/neuron_scan_ctrl.sv
module neuron_scan_ctrl
  import neuron_pe_pkg::*;
#(
  parameter int NUM_SLOTS = 64,
  localparam int IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busValid,
  output logic             busBusy,
  output logic [IDX_W-1:0] scanIdx,
  output ctrl_strobe_t     strobe
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SLOTS - 1);

  logic             busyQ;
  logic [IDX_W-1:0] idxQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busyQ <= 1'b0;
      idxQ  <= '0;
    end else if (busyQ) begin
      idxQ <= idxQ + 1'b1;
      if (idxQ == LAST_IDX) busyQ <= 1'b0;
    end else if (busValid) begin
      busyQ <= 1'b1;
      idxQ  <= '0;
    end
  end

  always_comb begin
    strobe.capture = busValid & ~busyQ;
    strobe.scanEn  = busyQ;
  end

  assign busBusy = busyQ;
  assign scanIdx = idxQ;

  // R6
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busyQ) |-> $past(idxQ) == LAST_IDX);

  // R6
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busyQ && idxQ != LAST_IDX) |=> (busyQ && idxQ == IDX_W'($past(idxQ) + 1'b1)));
endmodule

// File: rtl/neuron_mac_dp.sv
module neuron_mac_dp
  import neuron_pe_pkg::*;
#(
  parameter int NUM_SLOTS = 64,
  parameter int ADDR_W    = 10,
  parameter int VAL_W     = 9,
  parameter int WGT_W     = 16,
  parameter int ACC_W     = 32,
  localparam int IDX_W    = $clog2(NUM_SLOTS),
  localparam int PROD_W   = VAL_W + WGT_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  ctrl_strobe_t            strobe,
  input  logic [IDX_W-1:0]        scanIdx,
  input  logic [ADDR_W-1:0]       busAddr,
  input  logic signed [VAL_W-1:0] busValue,
  input  logic                    tblWrEn,
  input  logic [IDX_W-1:0]        tblWrIdx,
  input  logic [ADDR_W-1:0]       tblWrAddr,
  input  logic signed [WGT_W-1:0] tblWrWeight,
  input  logic                    accClear,
  output logic signed [ACC_W-1:0] accOut
);
  logic [ADDR_W-1:0]       capAddr;
  logic signed [VAL_W-1:0] capValue;
  logic [ADDR_W-1:0]       slotAddr   [NUM_SLOTS];
  logic signed [WGT_W-1:0] slotWeight [NUM_SLOTS];
  logic [NUM_SLOTS-1:0]    slotLive;
  logic signed [ACC_W-1:0] accQ;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prodExt;
  logic                     slotHit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      capAddr  <= '0;
      capValue <= '0;
    end else if (strobe.capture) begin
      capAddr  <= busAddr;
      capValue <= busValue;
    end
  end

  generate
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          slotAddr[s]   <= '0;
          slotWeight[s] <= '0;
          slotLive[s]   <= 1'b0;
        end else if (tblWrEn && tblWrIdx == IDX_W'(s)) begin
          slotAddr[s]   <= tblWrAddr;
          slotWeight[s] <= tblWrWeight;
          slotLive[s]   <= 1'b1;
        end
      end
    end
  endgenerate

  always_comb begin
    slotHit = strobe.scanEn && slotLive[scanIdx] && (slotAddr[scanIdx] == capAddr);
    prod    = capValue * slotWeight[scanIdx];
    prodExt = ACC_W'(prod);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       accQ <= '0;
    else if (accClear) accQ <= '0;
    else if (slotHit)  accQ <= accQ + prodExt;
  end

  assign accOut = accQ;

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accClear |=> accOut == '0);

  // R3
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.scanEn && !accClear) |=> $stable(accOut));

  // R7
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.scanEn |=> ($stable(capAddr) && $stable(capValue)));
endmodule

// File: rtl/neuron_bcast_pe.sv
module neuron_bcast_pe
  import neuron_pe_pkg::*;
#(
  parameter int NUM_SLOTS = 64,
  parameter int ADDR_W    = 10,
  parameter int VAL_W     = 9,
  parameter int WGT_W     = 16,
  parameter int ACC_W     = 32,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    busValid,
  input  logic [ADDR_W-1:0]       busAddr,
  input  logic signed [VAL_W-1:0] busValue,
  output logic                    busBusy,
  input  logic                    tblWrEn,
  input  logic [IDX_W-1:0]        tblWrIdx,
  input  logic [ADDR_W-1:0]       tblWrAddr,
  input  logic signed [WGT_W-1:0] tblWrWeight,
  input  logic                    accClear,
  output logic signed [ACC_W-1:0] accOut
);
  ctrl_strobe_t     strobe;
  logic [IDX_W-1:0] scanIdx;

  neuron_scan_ctrl #(.NUM_SLOTS(NUM_SLOTS)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .busValid(busValid),
    .busBusy(busBusy), .scanIdx(scanIdx), .strobe(strobe)
  );

  neuron_mac_dp #(
    .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .VAL_W(VAL_W),
    .WGT_W(WGT_W), .ACC_W(ACC_W)
  ) i_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .scanIdx(scanIdx),
    .busAddr(busAddr), .busValue(busValue),
    .tblWrEn(tblWrEn), .tblWrIdx(tblWrIdx), .tblWrAddr(tblWrAddr),
    .tblWrWeight(tblWrWeight), .accClear(accClear), .accOut(accOut)
  );
endmodule

// File: tb/test_neuron_bcast_pe.sv
module test_neuron_bcast_pe;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic busValid = 1'b0;
  logic [9:0] busAddr = '0;
  logic signed [8:0] busValue = '0;
  logic busBusy;
  logic tblWrEn = 1'b0;
  logic [5:0] tblWrIdx = '0;
  logic [9:0] tblWrAddr = '0;
  logic signed [15:0] tblWrWeight = '0;
  logic accClear = 1'b0;
  logic signed [31:0] accOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  // reference model state
  int  mAddr [64];
  int  mWgt  [64];
  bit  mLive [64];
  longint mAcc = 0;
  longint mPend = 0;
  int  mCount = 0;

  always #5 clk = ~clk;

  neuron_bcast_pe i_neuron_bcast_pe (
    .clk(clk), .rst_n(rst_n), .busValid(busValid), .busAddr(busAddr),
    .busValue(busValue), .busBusy(busBusy), .tblWrEn(tblWrEn),
    .tblWrIdx(tblWrIdx), .tblWrAddr(tblWrAddr), .tblWrWeight(tblWrWeight),
    .accClear(accClear), .accOut(accOut)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) begin mLive[i] = 1'b0; mAddr[i] = 0; mWgt[i] = 0; end
      mAcc = 0; mPend = 0; mCount = 0;
    end else begin
      if (accClear) mAcc = 0;
      else if (mCount == 1) mAcc = mAcc + mPend;
      if (mCount > 0) mCount--;
      else if (busValid) begin
        mPend = 0;
        for (int i = 0; i < 64; i++)
          if (mLive[i] && mAddr[i] == int'(busAddr)) mPend += longint'(mWgt[i]) * longint'(busValue);
        mCount = 64;
      end
      if (tblWrEn) begin
        mLive[tblWrIdx] = 1'b1;
        mAddr[tblWrIdx] = int'(tblWrAddr);
        mWgt[tblWrIdx]  = int'(tblWrWeight);
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(busBusy == (mCount != 0), "R6 busy", longint'(busBusy), longint'(mCount != 0));
      if (mCount == 0) check(longint'(accOut) == mAcc, "R2 acc", longint'(accOut), mAcc);
    end
  end

  task automatic wr(input int idx, input int addr, input int w);
    @(posedge clk); #1;
    tblWrEn = 1'b1; tblWrIdx = 6'(idx); tblWrAddr = 10'(addr); tblWrWeight = 16'(w);
    @(posedge clk); #1;
    tblWrEn = 1'b0;
  endtask

  int busyCnt;
  task automatic bcast(input int addr, input int val);
    @(posedge clk); #1;
    busValid = 1'b1; busAddr = 10'(addr); busValue = 9'(val);
    @(posedge clk); #1;
    busValid = 1'b0;
    busyCnt = 0;
    for (int k = 0; k < 70; k++) begin
      @(negedge clk);
      if (busBusy) busyCnt++;
    end
  endtask

  task automatic clr;
    @(posedge clk); #1; accClear = 1'b1;
    @(posedge clk); #1; accClear = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busBusy == 1'b0, "R1 busy", longint'(busBusy), 0);
    check(accOut == 0, "R1 acc", longint'(accOut), 0);
    // R9 empty slots never match, even address 0
    bcast(0, 5);
    check(accOut == 0, "R9", longint'(accOut), 0);
    wr(3, 7, 100);
    wr(40, 9, -3);
    wr(63, 7, 2);
    // R2 and R4: two slots with address 7 -> 10*100 + 10*2
    bcast(7, 10);
    check(accOut == 1020, "R4", longint'(accOut), 1020);
    check(busyCnt == 64, "R6 length", longint'(busyCnt), 64);
    // R5 signed: -20 * -3 = 60
    bcast(9, -20);
    check(accOut == 1080, "R5", longint'(accOut), 1080);
    // R3 miss
    bcast(12, 50);
    check(accOut == 1080, "R3", longint'(accOut), 1080);
    // R7 valid during busy ignored
    @(posedge clk); #1;
    busValid = 1'b1; busAddr = 10'd9; busValue = 9'sd1;
    @(posedge clk); #1; busValid = 1'b0;
    repeat (5) @(posedge clk);
    #1 busValid = 1'b1; busAddr = 10'd7; busValue = 9'sd100;
    @(posedge clk); #1 busValid = 1'b0;
    repeat (70) @(negedge clk);
    check(accOut == 1077, "R7", longint'(accOut), 1077);
    // R8 clear
    clr();
    @(negedge clk);
    check(accOut == 0, "R8", longint'(accOut), 0);
    // R10 overwrite slot 3: -1*10 + 2*10
    wr(3, 7, -1);
    bcast(7, 10);
    check(accOut == 10, "R10", longint'(accOut), 10);
    // R11 extreme magnitude
    clr();
    for (int i = 0; i < 64; i++) wr(i, 5, -32768);
    bcast(5, -256);
    check(accOut == 536870912, "R11 once", longint'(accOut), 536870912);
    bcast(5, -256);
    check(accOut == 1073741824, "R11 twice", longint'(accOut), 1073741824);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule